// File: doc/BRIEF.md
# Control Register Mode Unit

This block keeps the processor's mode-control state: the main control word (paging, write protect, protection enable, FPU control bits), the page-table base, the feature-enable word, the extended-feature word with its long-mode enable and active bits, and the address-line-20 gate mask. Software-side logic updates any of these through one plain write strobe. A select code picks the target. The write data carries the new value.

A write is more than a store. When it reaches the control word, the block can enter or leave long mode. It forces the extension-type bit on and re-derives the hidden mode flags that decode and FPU logic consume. Some writes alter translation-relevant bits. Those writes send a one-cycle flush pulse to the translation cache. Toggling the address-line-20 gate also sends a one-cycle pulse that asks the pipeline to leave its current code block. Leaving long mode sends a pulse that tells the fetch logic to cut its instruction pointer down to 32 bits.

All inputs are level or strobe control pins. There is no stream and no back-pressure. A write is accepted in the cycle its strobe is sampled high, and every result appears after that clock edge.

Top module: `ctrl_mode_unit`

## Requirements
- R1: After reset, the control word reads 0x60000010, the address mask reads 0xFFFFFFFF, the base, feature and extended words read 0, and the flush, exit and truncate pulses are low.
- R2: Select code 0 writes the control word. The stored value is the written data with bit 4 forced to 1, and it is visible on the clock edge that samples the strobe.
- R3: A control-word write that changes bit 31 (paging), bit 16 (write protect) or bit 0 (protection enable) raises tlb_flush for exactly the cycle after that edge. A write that changes none of them raises no flush.
- R4: Select code 2 writes the feature word. The write raises the flush pulse only when bit 4, bit 5 (physical address extension) or bit 7 (global pages) changes.
- R5: A control-word write that takes bit 31 from 0 to 1 while extended bit 8 (long-mode enable) is 1 sets extended bit 10 (long-mode active), provided feature bit 5 is 1. If feature bit 5 is 0, the write is refused: the control word is unchanged and no flush is raised.
- R6: A control-word write that takes bit 31 from 1 to 0 while extended bit 10 is 1 clears bit 10 and raises ip_trunc for one cycle.
- R7: hflags bit 0 equals control bit 0. Bit 1 is 1 whenever control bit 0 is 0 and otherwise follows addseg_in. Bits 2, 3 and 4 equal control bits 1, 2 and 3. Bit 5 equals extended bit 10.
- R8: Select code 4 sets the address-line-20 level to wr_data[0]. The mask becomes 0xFFEFFFFF with bit 20 set to that level. Only a level different from current mask bit 20 changes the mask, and that change pulses tlb_flush and exit_block together for one cycle.
- R9: Select code 1 stores the base word. The write raises tlb_flush only when control bit 31 is 1.
- R10: Select code 3 stores the extended word except bit 10, which software cannot change. Bit 10 keeps its current value.
- R11: Select codes 5 to 7, and cycles with wr_en low, change no register and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Target select: 0 control, 1 base, 2 feature, 3 extended, 4 address-line-20 level |
| wr_data | input | 32 | Write value (bit 0 only for select 4) |
| addseg_in | input | 1 | Segment-add request from segmentation logic, used in protected mode |
| cr0 | output | 32 | Control word |
| cr3 | output | 32 | Page-table base word |
| cr4 | output | 32 | Feature-enable word |
| efer | output | 32 | Extended-feature word including the long-mode active bit |
| a20_mask | output | 32 | Address mask for line 20 |
| hflags | output | 6 | Hidden flags: pe, addseg, mp, em, ts, lma (bit 0 upward) |
| tlb_flush | output | 1 | One-cycle translation flush request |
| exit_block | output | 1 | One-cycle request to leave the current code block |
| ip_trunc | output | 1 | One-cycle request to cut the instruction pointer to 32 bits |

## Verification
Some properties are checked on every cycle: the extension-type bit stays set, the address mask differs from all ones in bit 20 at most, long mode turns active only under physical address extension, every exit request comes with a flush, every pulse traces back to a write, and leaving long mode always raises the truncate pulse. Other behaviour can only be shown by the bench scenarios. That covers the exact stored values, the refusal of a long-mode entry, whether a given bit change flushes or not, the dependence of the base-word flush on paging, and the effect of ignored select codes. The bench checks these against a reference model.

// File: rtl/ctrl_mode_pkg.sv
package ctrl_mode_pkg;
  localparam int unsigned CM_DW = 32;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_BASE  = 3'd1,
    SEL_FEAT  = 3'd2,
    SEL_EXT   = 3'd3,
    SEL_GATE  = 3'd4
  } wsel_e;

  // control word bit positions
  localparam int unsigned C_PE = 0;
  localparam int unsigned C_MP = 1;
  localparam int unsigned C_EM = 2;
  localparam int unsigned C_TS = 3;
  localparam int unsigned C_ET = 4;
  localparam int unsigned C_WP = 16;
  localparam int unsigned C_PG = 31;

  // feature word bit positions
  localparam int unsigned F_PSE = 4;
  localparam int unsigned F_PAE = 5;
  localparam int unsigned F_PGE = 7;

  // extended word bit positions
  localparam int unsigned X_LME = 8;
  localparam int unsigned X_LMA = 10;

  localparam int unsigned GATE_BIT = 20;

  typedef struct packed {
    logic lma;
    logic ts;
    logic em;
    logic mp;
    logic addseg;
    logic pe;
  } hflag_t;
endpackage

// File: rtl/cm_ctrl_word.sv
module cm_ctrl_word
  import ctrl_mode_pkg::*;
#(
  parameter int unsigned DW = CM_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          lme,
  input  logic          pae,
  output logic [DW-1:0] ctrl_q,
  output logic          lma_q,
  output logic          flush_req,
  output logic          trunc_req
);
  localparam logic [DW-1:0] RST_VAL   = DW'(32'h6000_0010);
  localparam logic [DW-1:0] ET_MASK   = DW'(1) << C_ET;
  localparam logic [DW-1:0] WATCH_MSK = (DW'(1) << C_PG) | (DW'(1) << C_WP) | (DW'(1) << C_PE);

  logic pg_now, pg_next, go_long, refuse, leave_long, take;

  always_comb begin
    pg_now     = ctrl_q[C_PG];
    pg_next    = wdata[C_PG];
    go_long    = wr && !pg_now && pg_next && lme;
    refuse     = go_long && !pae;
    leave_long = wr && pg_now && !pg_next && lma_q;
    take       = wr && !refuse;
    flush_req  = take && (((wdata ^ ctrl_q) & WATCH_MSK) != '0);
    trunc_req  = leave_long;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= RST_VAL;
      lma_q  <= 1'b0;
    end else begin
      if (take)
        ctrl_q <= wdata | ET_MASK;
      if (go_long && pae)
        lma_q <= 1'b1;
      else if (leave_long)
        lma_q <= 1'b0;
    end
  end

  AST_ET_STUCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[C_ET]) else $error("extension-type bit low"); // R2

  AST_LMA_NEEDS_PAE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lma_q) |-> ($past(pae) && ctrl_q[C_PG])) else $error("long mode without PAE"); // R5
endmodule

// File: rtl/cm_aux_regs.sv
module cm_aux_regs
  import ctrl_mode_pkg::*;
#(
  parameter int unsigned DW = CM_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_base,
  input  logic          wr_feat,
  input  logic          wr_ext,
  input  logic [DW-1:0] wdata,
  input  logic          paging,
  output logic [DW-1:0] base_q,
  output logic [DW-1:0] feat_q,
  output logic [DW-1:0] ext_q,
  output logic          flush_req
);
  localparam logic [DW-1:0] FEAT_WATCH = (DW'(1) << F_PSE) | (DW'(1) << F_PAE) | (DW'(1) << F_PGE);
  localparam logic [DW-1:0] LMA_CLR    = ~(DW'(1) << X_LMA);

  always_comb begin
    flush_req = (wr_base && paging) ||
                (wr_feat && (((wdata ^ feat_q) & FEAT_WATCH) != '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      feat_q <= '0;
      ext_q  <= '0;
    end else begin
      if (wr_base) base_q <= wdata;
      if (wr_feat) feat_q <= wdata;
      if (wr_ext)  ext_q  <= wdata & LMA_CLR;
    end
  end

  AST_EXT_NO_LMA_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ext |=> !ext_q[X_LMA]) else $error("active bit stored from software"); // R10
endmodule

// File: rtl/cm_gate20.sv
module cm_gate20
  import ctrl_mode_pkg::*;
#(
  parameter int unsigned DW = CM_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          level,
  output logic [DW-1:0] mask_q,
  output logic          change
);
  localparam logic [DW-1:0] LOW_MASK = ~(DW'(1) << GATE_BIT);

  always_comb change = wr && (level != mask_q[GATE_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= '1;
    else if (change)
      mask_q <= LOW_MASK | (DW'(level) << GATE_BIT);
  end

  AST_MASK_ONLY_BIT20: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q | ~LOW_MASK) == '1) else $error("mask bit outside line 20 cleared"); // R8
endmodule

// File: rtl/ctrl_mode_unit.sv
module ctrl_mode_unit
  import ctrl_mode_pkg::*;
#(
  parameter int unsigned DW = CM_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          addseg_in,
  output logic [DW-1:0] cr0,
  output logic [DW-1:0] cr3,
  output logic [DW-1:0] cr4,
  output logic [DW-1:0] efer,
  output logic [DW-1:0] a20_mask,
  output logic [5:0]    hflags,
  output logic          tlb_flush,
  output logic          exit_block,
  output logic          ip_trunc
);
  logic wr_ctrl, wr_base, wr_feat, wr_ext, wr_gate;
  logic lma, ctrl_flush, ctrl_trunc, aux_flush, gate_chg;
  logic [DW-1:0] ext_raw;
  hflag_t hf;

  always_comb begin
    wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
    wr_base = wr_en && (wr_sel == SEL_BASE);
    wr_feat = wr_en && (wr_sel == SEL_FEAT);
    wr_ext  = wr_en && (wr_sel == SEL_EXT);
    wr_gate = wr_en && (wr_sel == SEL_GATE);
  end

  cm_ctrl_word #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(wr_data),
    .lme(ext_raw[X_LME]), .pae(cr4[F_PAE]),
    .ctrl_q(cr0), .lma_q(lma), .flush_req(ctrl_flush), .trunc_req(ctrl_trunc)
  );

  cm_aux_regs #(.DW(DW)) u_aux (
    .clk(clk), .rst_n(rst_n), .wr_base(wr_base), .wr_feat(wr_feat),
    .wr_ext(wr_ext), .wdata(wr_data), .paging(cr0[C_PG]),
    .base_q(cr3), .feat_q(cr4), .ext_q(ext_raw), .flush_req(aux_flush)
  );

  cm_gate20 #(.DW(DW)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr(wr_gate), .level(wr_data[0]),
    .mask_q(a20_mask), .change(gate_chg)
  );

  always_comb begin
    efer          = ext_raw;
    efer[X_LMA]   = lma;
    hf.pe         = cr0[C_PE];
    hf.addseg     = !cr0[C_PE] || addseg_in;
    hf.mp         = cr0[C_MP];
    hf.em         = cr0[C_EM];
    hf.ts         = cr0[C_TS];
    hf.lma        = lma;
    hflags        = hf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tlb_flush  <= 1'b0;
      exit_block <= 1'b0;
      ip_trunc   <= 1'b0;
    end else begin
      tlb_flush  <= ctrl_flush || aux_flush || gate_chg;
      exit_block <= gate_chg;
      ip_trunc   <= ctrl_trunc;
    end
  end

  AST_EXIT_WITH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    exit_block |-> tlb_flush) else $error("exit without flush"); // R8

  AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_flush || ip_trunc) |-> $past(wr_en)) else $error("pulse without write"); // R11

  AST_TRUNC_ON_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lma) |-> ip_trunc) else $error("long mode left without truncate"); // R6
endmodule

// File: tb/test_ctrl_mode_unit.sv
module test_ctrl_mode_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic addseg_in = 1'b0;
  logic [31:0] cr0, cr3, cr4, efer, a20_mask;
  logic [5:0] hflags;
  logic tlb_flush, exit_block, ip_trunc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m_cr0, m_cr3, m_cr4, m_ext, m_mask;
  logic m_lma, e_flush, e_exit, e_trunc;

  always #5 clk = ~clk;

  ctrl_mode_unit i_ctrl_mode_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .addseg_in(addseg_in), .cr0(cr0), .cr3(cr3), .cr4(cr4), .efer(efer),
    .a20_mask(a20_mask), .hflags(hflags), .tlb_flush(tlb_flush),
    .exit_block(exit_block), .ip_trunc(ip_trunc)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_efer();
    logic [31:0] v = m_ext;
    v[10] = m_lma;
    return v;
  endfunction

  function automatic logic [5:0] exp_hflags();
    logic pe = m_cr0[0];
    return {m_lma, m_cr0[3], m_cr0[2], m_cr0[1], (!pe || addseg_in), pe};
  endfunction

  // model of one write; sets expected pulses
  function automatic void model_write(logic [2:0] sel, logic [31:0] d);
    logic go, lv;
    e_flush = 0; e_exit = 0; e_trunc = 0;
    case (sel)
      3'd0: begin
        go = !m_cr0[31] && d[31] && m_ext[8];
        lv = m_cr0[31] && !d[31] && m_lma;
        if (!(go && !m_cr4[5])) begin
          e_flush = ((d ^ m_cr0) & 32'h8001_0001) != 0;
          m_cr0 = d | 32'h10;
          if (go) m_lma = 1;
          if (lv) begin m_lma = 0; e_trunc = 1; end
        end
      end
      3'd1: begin m_cr3 = d; e_flush = m_cr0[31]; end
      3'd2: begin e_flush = ((d ^ m_cr4) & 32'hB0) != 0; m_cr4 = d; end
      3'd3: m_ext = d & ~32'h400;
      3'd4: if (d[0] != m_mask[20]) begin
              m_mask = 32'hFFEF_FFFF | (32'(d[0]) << 20);
              e_flush = 1; e_exit = 1;
            end
      default: ;
    endcase
  endfunction

  task automatic check_all(string req);
    chk(req, "cr0", cr0, m_cr0);
    chk(req, "cr3", cr3, m_cr3);
    chk(req, "cr4", cr4, m_cr4);
    chk(req, "efer", efer, exp_efer());
    chk(req, "mask", a20_mask, m_mask);
    chk(req, "hflags", 32'(hflags), 32'(exp_hflags()));
    chk(req, "flush", 32'(tlb_flush), 32'(e_flush));
    chk(req, "exit", 32'(exit_block), 32'(e_exit));
    chk(req, "trunc", 32'(ip_trunc), 32'(e_trunc));
  endtask

  // drive at negedge, edge captures, check at next negedge
  task automatic do_write(logic [2:0] sel, logic [31:0] d, string req);
    wr_en = 1; wr_sel = sel; wr_data = d;
    model_write(sel, d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
    check_all(req);
  endtask

  task automatic idle_check(string req);
    @(negedge clk);
    e_flush = 0; e_exit = 0; e_trunc = 0;
    check_all(req);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cr0 = 32'h6000_0010; m_cr3 = 0; m_cr4 = 0; m_ext = 0;
    m_mask = 32'hFFFF_FFFF; m_lma = 0; e_flush = 0; e_exit = 0; e_trunc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    // R2: bit 4 forced, no watched change
    do_write(3'd0, 32'h6000_0000, "R2");
    // R3: PE change flushes
    do_write(3'd0, 32'h0000_0001, "R3");
    do_write(3'd0, 32'h0000_000F, "R3");
    idle_check("R11");
    // R7 addseg follows input in protected mode
    addseg_in = 1; idle_check("R7");
    addseg_in = 0; idle_check("R7");
    // R4 feature word
    do_write(3'd2, 32'h0000_0100, "R4");
    do_write(3'd2, 32'h0000_0120, "R4");
    // R10 extended: try to set LMA, set LME
    do_write(3'd3, 32'h0000_0500, "R10");
    // R5 refused entry without PAE
    do_write(3'd2, 32'h0, "R4");
    do_write(3'd0, 32'h8000_0001, "R5");
    // R5 entry with PAE
    do_write(3'd2, 32'h20, "R4");
    do_write(3'd0, 32'h8000_0001, "R5");
    // R9 base with paging on
    do_write(3'd1, 32'h0012_3000, "R9");
    // R6 leave long mode
    do_write(3'd0, 32'h0000_0001, "R6");
    do_write(3'd1, 32'h0045_6000, "R9");
    // R8 gate
    do_write(3'd4, 32'h0, "R8");
    do_write(3'd4, 32'h0, "R8");
    do_write(3'd4, 32'h1, "R8");
    // R11 invalid selects
    do_write(3'd5, 32'hFFFF_FFFF, "R11");
    do_write(3'd7, 32'h0, "R11");

    for (int i = 0; i < 600; i++) begin
      logic [2:0] s = 3'($urandom_range(0, 7));
      logic [31:0] d = $urandom;
      addseg_in = 1'($urandom);
      if ($urandom_range(0, 3) == 0) idle_check("R11");
      else do_write(s, d, "R3");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule